// File: doc/BRIEF.md
# Configuration SRAM Bank Write Sequencer

This block sits behind a configuration stream parser. When the parser has decoded a data command for one of the configuration memory banks, it pulses a start strobe. With the strobe it presents the geometry it has already latched from earlier commands: the bank kind (logic configuration or block memory), the bank number, the row width in bits, the chunk height in rows and the starting row offset. The sequencer then takes exactly width×height/8 payload bytes from the byte stream. It turns each byte into eight single-bit write requests. Each request carries a bank code, a row, a column and the data bit.

Bits leave in row-major order, most significant bit of each byte first. The first bit lands at column 0 of the row given by the offset. After `width` bits the column returns to 0 and the row advances. A tall bank can therefore be filled in several shorter chunks, each placed by its own offset.

Two trailer bytes follow every payload, and both must be zero. A nonzero trailer byte raises the error flag, but control still goes back to the parser. A geometry whose bit count is not a multiple of eight is rejected at once, and no bytes are taken and no writes are issued. The write port is valid/ready, one bit per cycle at most. The byte input is stalled while the eight bits of the current byte are going out.

Top module: `cfg_bank_writer`

## Requirements
- R1: After reset, byte_ready_o, wr_valid_o, busy_o, done_o and err_o are all 0.
- R2: For an accepted geometry, the block accepts exactly width×height/8 payload bytes, issues exactly width×height bit writes, and then accepts exactly two trailer bytes.
- R3: Write k of a block (k from 0) carries bit (7 − k mod 8) of payload byte k/8 as wr_data_o, with wr_col_o = k mod width and wr_row_o = offset + k/width.
- R4: wr_bank_o bit 2 equals kind_i (1 = block memory, 0 = logic configuration) and wr_bank_o bits 1:0 equal bank_i, both as sampled at the accepted start.
- R5: While wr_valid_o is 1 and wr_ready_i is 0, wr_valid_o, wr_bank_o, wr_row_o, wr_col_o and wr_data_o stay unchanged into the next cycle, and at most one write completes per cycle.
- R6: err_o ends a block at 0 when both trailer bytes are 0x00, and at 1 when either trailer byte is nonzero. A nonzero trailer byte does not stop the block from completing.
- R7: If width×height is not a multiple of 8, done_o and err_o are 1 in the cycle after the start, no byte is accepted and no write is issued.
- R8: done_o is a single-cycle pulse in the cycle after the second trailer byte is accepted. busy_o is 0 in the cycle after done_o. err_o holds its value until the next accepted start.
- R9: start_i while busy_o is 1 has no effect on the running block, and bytes presented while idle are not accepted (byte_ready_o stays 0).
- R10: A geometry with width×height = 0 issues no writes and goes straight to accepting the two trailer bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe from the parser; taken only while idle |
| kind_i | input | 1 | Bank kind: 0 logic configuration, 1 block memory |
| bank_i | input | BANK_W | Bank number |
| width_i | input | DIM_W | Row width in bits |
| height_i | input | DIM_W | Chunk height in rows |
| offset_i | input | DIM_W | First row of the chunk |
| byte_i | input | 8 | Stream byte |
| byte_valid_i | input | 1 | Stream byte present |
| byte_ready_o | output | 1 | Byte taken at this edge when valid |
| wr_valid_o | output | 1 | Bit write request |
| wr_ready_i | input | 1 | Bank side accepts the write |
| wr_bank_o | output | BANK_W+1 | Bank code {kind, bank number} |
| wr_row_o | output | DIM_W+1 | Target row |
| wr_col_o | output | DIM_W | Target column |
| wr_data_o | output | 1 | Bit value |
| busy_o | output | 1 | A block is in progress |
| done_o | output | 1 | Single-cycle end-of-block pulse |
| err_o | output | 1 | Error for the last block |

## Verification
A payload byte is taken at the edge where byte_valid_i and byte_ready_o are both high. Its first bit request is visible right after that edge, and each further bit appears after the edge that completes the previous write. The bench applies wr_ready_i a little after the falling edge and samples every write request 1 ns later, still before the rising edge that completes the transfer, so each compared bit is the one that edge will take. done_o and err_o are due in the cycle after the rising edge that takes the second trailer byte, or after the start edge for a rejected geometry. The bench reads them just after that edge, and reads busy_o one edge later.

// File: rtl/cfg_bw_pkg.sv
package cfg_bw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DATA  = 2'd1,
    ST_TRAIL = 2'd2,
    ST_DONE  = 2'd3
  } bw_state_e;
endpackage

// File: rtl/cfg_bw_geom.sv
module cfg_bw_geom #(
  parameter int DIM_W = 8,
  localparam int PROD_W = 2 * DIM_W,
  localparam int CNT_W = PROD_W - 3
) (
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  output logic             bad_o,
  output logic             zero_o,
  output logic [CNT_W-1:0] nbytes_o
);
  logic [PROD_W-1:0] prod;

  always_comb begin
    prod     = PROD_W'(width_i) * PROD_W'(height_i);
    bad_o    = |prod[2:0];
    zero_o   = (prod == '0);
    nbytes_o = prod[PROD_W-1:3];
  end
endmodule

// File: rtl/cfg_bw_serializer.sv
module cfg_bw_serializer (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       step_i,
  output logic       have_o,
  output logic       last_o,
  output logic       bit_o
);
  logic [7:0] sh_q;
  logic [2:0] left_q;
  logic       have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      have_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= byte_i;
      left_q <= 3'd7;
      have_q <= 1'b1;
    end else if (step_i && have_q) begin
      sh_q <= {sh_q[6:0], 1'b0};
      if (left_q == 3'd0) have_q <= 1'b0;
      else left_q <= left_q - 3'd1;
    end
  end

  assign have_o = have_q;
  assign last_o = (left_q == 3'd0);
  assign bit_o  = sh_q[7];

  // load only into an empty serializer (R2)
  assert_load_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !have_q);
endmodule

// File: rtl/cfg_bw_walker.sv
module cfg_bw_walker #(
  parameter int DIM_W = 8,
  localparam int ROW_W = DIM_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] offset_i,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o,
  output logic [DIM_W-1:0] col_o,
  output logic [DIM_W-1:0] width_o
);
  logic [DIM_W-1:0] width_q, col_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q <= '0;
      col_q   <= '0;
      row_q   <= '0;
    end else if (load_i) begin
      width_q <= width_i;
      col_q   <= '0;
      row_q   <= {1'b0, offset_i};
    end else if (step_i) begin
      if (col_q == width_q - DIM_W'(1)) begin
        col_q <= '0;
        row_q <= row_q + ROW_W'(1);
      end else begin
        col_q <= col_q + DIM_W'(1);
      end
    end
  end

  assign row_o   = row_q;
  assign col_o   = col_q;
  assign width_o = width_q;

  // row only moves forward by one at a column wrap (R3)
  assert_row_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (row_q == $past(row_q)) || (row_q == $past(row_q) + ROW_W'(1) && col_q == '0));
endmodule

// File: rtl/cfg_bw_ctrl.sv
module cfg_bw_ctrl
  import cfg_bw_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             geom_bad_i,
  input  logic             geom_zero_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic             have_i,
  input  logic             step_i,
  input  logic             last_i,
  output logic             accept_o,
  output logic             load_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  bw_state_e        state_q;
  logic [CNT_W-1:0] left_q;
  logic             tcnt_q;
  logic             err_q;
  logic             fire;

  assign accept_o     = start_i && (state_q == ST_IDLE);
  assign byte_ready_o = ((state_q == ST_DATA) && !have_i) || (state_q == ST_TRAIL);
  assign fire         = byte_ready_o && byte_valid_i;
  assign load_o       = fire && (state_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      tcnt_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          err_q   <= geom_bad_i;
          left_q  <= nbytes_i;
          tcnt_q  <= 1'b0;
          state_q <= geom_bad_i ? ST_DONE : (geom_zero_i ? ST_TRAIL : ST_DATA);
        end
        ST_DATA: begin
          if (load_o) left_q <= left_q - CNT_W'(1);
          if (step_i && last_i && left_q == '0) state_q <= ST_TRAIL;
        end
        ST_TRAIL: if (fire) begin
          if (byte_i != 8'h00) err_q <= 1'b1;
          tcnt_q <= 1'b1;
          if (tcnt_q) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
  assign err_o  = err_q;

  assert_idle_no_byte_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !byte_ready_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  assert_bad_geom_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && geom_bad_i) |=> done_o && err_o);
  assert_write_in_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    have_i |-> (state_q == ST_DATA));
endmodule

// File: rtl/cfg_bank_writer.sv
module cfg_bank_writer #(
  parameter int DIM_W  = 8,
  parameter int BANK_W = 2,
  localparam int ROW_W = DIM_W + 1,
  localparam int CNT_W = 2 * DIM_W - 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              kind_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [DIM_W-1:0]  offset_i,
  input  logic [7:0]        byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [BANK_W:0]   wr_bank_o,
  output logic [ROW_W-1:0]  wr_row_o,
  output logic [DIM_W-1:0]  wr_col_o,
  output logic              wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  logic             geom_bad, geom_zero;
  logic [CNT_W-1:0] nbytes;
  logic             accept, load, have, last, step;
  logic [BANK_W:0]  bank_q;
  logic [DIM_W-1:0] width_l;

  assign step = have && wr_ready_i;

  cfg_bw_geom #(.DIM_W(DIM_W)) u_geom (
    .width_i (width_i),
    .height_i(height_i),
    .bad_o   (geom_bad),
    .zero_o  (geom_zero),
    .nbytes_o(nbytes)
  );

  cfg_bw_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .geom_bad_i  (geom_bad),
    .geom_zero_i (geom_zero),
    .nbytes_i    (nbytes),
    .byte_i      (byte_i),
    .byte_valid_i(byte_valid_i),
    .byte_ready_o(byte_ready_o),
    .have_i      (have),
    .step_i      (step),
    .last_i      (last),
    .accept_o    (accept),
    .load_o      (load),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  cfg_bw_serializer u_ser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .byte_i(byte_i),
    .step_i(step),
    .have_o(have),
    .last_o(last),
    .bit_o (wr_data_o)
  );

  cfg_bw_walker #(.DIM_W(DIM_W)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .width_i (width_i),
    .offset_i(offset_i),
    .step_i  (step),
    .row_o   (wr_row_o),
    .col_o   (wr_col_o),
    .width_o (width_l)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_q <= '0;
    else if (accept) bank_q <= {kind_i, bank_i};
  end

  assign wr_valid_o = have;
  assign wr_bank_o  = bank_q;

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> wr_valid_o && $stable(wr_data_o) && $stable(wr_row_o)
                                    && $stable(wr_col_o) && $stable(wr_bank_o));
  assert_col_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (wr_col_o < width_l));
  assert_bank_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !accept) |=> $stable(wr_bank_o));
endmodule

// File: tb/sim_cfg_bank_writer.sv
`timescale 1ns/1ps
module sim_cfg_bank_writer;
  localparam int DIM_W = 8;
  localparam int BANK_W = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, kind_i = 1'b0;
  logic [BANK_W-1:0] bank_i = '0;
  logic [DIM_W-1:0] width_i = '0, height_i = '0, offset_i = '0;
  logic [7:0] byte_i = '0;
  logic byte_valid_i = 1'b0, byte_ready_o;
  logic wr_valid_o, wr_ready_i = 1'b1;
  logic [BANK_W:0] wr_bank_o;
  logic [DIM_W:0] wr_row_o;
  logic [DIM_W-1:0] wr_col_o;
  logic wr_data_o, busy_o, done_o, err_o;

  cfg_bank_writer #(.DIM_W(DIM_W), .BANK_W(BANK_W)) u0 (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int wr_idx = 0;
  int cur_w = 1, cur_off = 0, cur_bank = 0;
  logic [7:0] payload [0:255];
  logic bp_en = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  logic prev_stall = 1'b0;
  logic [BANK_W:0] h_bank; logic [DIM_W:0] h_row; logic [DIM_W-1:0] h_col; logic h_dat;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // write collector: ready set after falling edge, request sampled 1 ns later
  always @(negedge clk_i) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_ready_i = bp_en ? lfsr[0] : 1'b1;
    #1;
    if (rst_ni) begin
      if (prev_stall) begin
        chk(wr_valid_o && wr_bank_o == h_bank && wr_row_o == h_row && wr_col_o == h_col
            && wr_data_o == h_dat, "R5 hold", int'(wr_row_o), int'(h_row));
      end
      prev_stall = wr_valid_o && !wr_ready_i;
      h_bank = wr_bank_o; h_row = wr_row_o; h_col = wr_col_o; h_dat = wr_data_o;
      if (wr_valid_o && wr_ready_i) begin
        chk(wr_data_o == payload[wr_idx / 8][7 - (wr_idx % 8)], "R3 data",
            int'(wr_data_o), int'(payload[wr_idx / 8][7 - (wr_idx % 8)]));
        chk(int'(wr_col_o) == wr_idx % cur_w, "R3 col", int'(wr_col_o), wr_idx % cur_w);
        chk(int'(wr_row_o) == cur_off + wr_idx / cur_w, "R3 row", int'(wr_row_o),
            cur_off + wr_idx / cur_w);
        chk(int'(wr_bank_o) == cur_bank, "R4 bank", int'(wr_bank_o), cur_bank);
        wr_idx++;
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk_i);
    byte_i = b; byte_valid_i = 1'b1;
    #2;
    while (!byte_ready_o) begin
      @(negedge clk_i); #2;
    end
    @(posedge clk_i); #1;
    byte_valid_i = 1'b0;
  endtask

  task automatic run_block(input int kind, input int bank, input int w, input int h,
                           input int off, input logic [7:0] t0, input logic [7:0] t1,
                           input bit exp_err, input bit poke);
    int nb;
    cur_w = (w == 0) ? 1 : w; cur_off = off; cur_bank = kind * 4 + bank;
    wr_idx = 0;
    for (int i = 0; i < 256; i++) payload[i] = 8'((i * 37 + w * 5 + h * 11) & 255);
    @(negedge clk_i);
    start_i = 1'b1; kind_i = kind[0]; bank_i = bank[1:0];
    width_i = w[7:0]; height_i = h[7:0]; offset_i = off[7:0];
    @(posedge clk_i); #1;
    start_i = 1'b0;
    if ((w * h) % 8 != 0) begin
      chk(done_o === 1'b1, "R7 done", int'(done_o), 1);
      chk(err_o === 1'b1, "R7 err", int'(err_o), 1);
      chk(byte_ready_o === 1'b0, "R7 no byte", int'(byte_ready_o), 0);
      @(posedge clk_i); #1;
      chk(busy_o === 1'b0 && wr_idx == 0, "R7 no writes", wr_idx, 0);
      return;
    end
    nb = w * h / 8;
    for (int i = 0; i < nb; i++) begin
      send_byte(payload[i]);
      if (poke && i == 0) begin
        @(negedge clk_i);
        start_i = 1'b1; width_i = 8'd3; height_i = 8'd3; offset_i = 8'd7; kind_i = ~kind_i;
        @(posedge clk_i); #1;
        start_i = 1'b0;
      end
    end
    if (h == 0) chk(byte_ready_o === 1'b1 && wr_idx == 0, "R10 trailer", int'(byte_ready_o), 1);
    send_byte(t0);
    chk(done_o === 1'b0, "R2 one trailer byte not enough", int'(done_o), 0);
    send_byte(t1);
    chk(done_o === 1'b1, "R8 done after trailer", int'(done_o), 1);
    chk(err_o === exp_err, "R6 err", int'(err_o), int'(exp_err));
    chk(wr_idx == w * h, "R2 write count", wr_idx, w * h);
    @(posedge clk_i); #1;
    chk(done_o === 1'b0 && busy_o === 1'b0, "R8 idle after done", int'(busy_o), 0);
    chk(err_o === exp_err, "R8 err held", int'(err_o), int'(exp_err));
  endtask

  initial begin
    #35;
    chk(byte_ready_o === 1'b0 && wr_valid_o === 1'b0 && busy_o === 1'b0
        && done_o === 1'b0 && err_o === 1'b0, "R1 reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    // bytes while idle are not taken (R9)
    @(negedge clk_i);
    byte_i = 8'hA5; byte_valid_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i); #2;
      chk(byte_ready_o === 1'b0 && wr_valid_o === 1'b0, "R9 idle bytes", int'(byte_ready_o), 0);
    end
    byte_valid_i = 1'b0;
    // sweep of small geometries
    for (int w = 1; w <= 9; w++) begin
      for (int h = 0; h <= 8; h++) begin
        bp_en = w[0];
        run_block(w % 2, h % 4, w, h, (w * 13 + h * 7) % 250, 8'h00, 8'h00,
                  ((w * h) % 8) != 0, 1'b0);
      end
    end
    bp_en = 1'b1;
    run_block(1, 3, 8, 8, 250, 8'h00, 8'h00, 1'b0, 1'b0);
    run_block(0, 2, 16, 2, 5, 8'h01, 8'h00, 1'b1, 1'b0);
    run_block(1, 1, 4, 2, 9, 8'h00, 8'h80, 1'b1, 1'b0);
    run_block(0, 0, 8, 1, 3, 8'h00, 8'h00, 1'b0, 1'b0);
    run_block(1, 2, 24, 3, 40, 8'h00, 8'h00, 1'b0, 1'b1);
    bp_en = 1'b0;
    run_block(0, 1, 255, 8, 100, 8'h00, 8'h00, 1'b0, 1'b0);
    run_block(1, 0, 5, 0, 0, 8'h00, 8'h00, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule